// File: doc/BRIEF.md
# Highway and Farmroad Intersection Light Controller

This block runs the lamps at a crossing where a busy highway meets a lightly used farmroad. The highway has priority. Its green lamp stays lit until two things are both true: a vehicle is waiting on the farmroad, and a long interval has run out. The controller then moves through a highway yellow phase to a farmroad green phase. The farmroad keeps its green only while vehicles are still waiting and the long interval has not yet run out. A farmroad yellow phase then returns the crossing to highway green. Each yellow phase lasts exactly one short interval.

The block has four phases held in one state register. The six lamp outputs are decoded from that register alone. On every phase change the controller raises a one-cycle start pulse, and this pulse restarts an internal interval counter. That counter drives two flags, short-expired and long-expired. Each flag rises when the count reaches its own parameter and then stays high until the next start pulse. The vehicle sensor input is assumed to be already clean and synchronous to the clock.

Top module: `hwy_farm_light_ctrl`

## Requirements
- R1: The reset is synchronous and active high. After a clock edge with reset high, the lamps show the highway-green pattern (highway green and farmroad red), and start_timer, short_done and long_done are all low. start_timer stays low for as long as reset is high.
- R2: In every cycle exactly one lamp of each road is lit. The lamp order is {green, yellow, red}. The patterns are: highway green = {hwy 100, farm 001}, highway yellow = {010, 001}, farmroad green = {001, 100}, farmroad yellow = {001, 010}.
- R3: In highway green, the controller leaves for highway yellow only in a cycle where both car_waiting and long_done are high. At any other time highway green is held.
- R4: In highway yellow, the controller moves to farmroad green in the cycle where short_done is high, whatever car_waiting is.
- R5: In farmroad green, the controller moves to farmroad yellow in any cycle where long_done is high or car_waiting is low. It stays in farmroad green only while car_waiting is high and long_done is low.
- R6: In farmroad yellow, the controller moves to highway green in the cycle where short_done is high.
- R7: start_timer is high in exactly those cycles after which the phase changes at the next clock edge. It lasts one cycle for each change.
- R8: A start pulse clears the counter. After the clearing edge, short_done is high from SHORT_CYC edges onward, and long_done is high from LONG_CYC edges onward. Both flags stay high until the next start pulse.
- R9: When no vehicle is waiting, highway green is held indefinitely, even after long_done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| car_waiting | input | 1 | A vehicle is present on the farmroad |
| hwy_green | output | 1 | Highway green lamp |
| hwy_yellow | output | 1 | Highway yellow lamp |
| hwy_red | output | 1 | Highway red lamp |
| farm_green | output | 1 | Farmroad green lamp |
| farm_yellow | output | 1 | Farmroad yellow lamp |
| farm_red | output | 1 | Farmroad red lamp |
| start_timer | output | 1 | One-cycle pulse that restarts the interval counter on a phase change |
| short_done | output | 1 | The short interval has run out since the last start pulse |
| long_done | output | 1 | The long interval has run out since the last start pulse |

## Verification
Two functions can fall in the same cycle, and the bench provokes both coincidences.

The first coincidence happens in farmroad green. The long_done flag and a low car_waiting are both legal exit causes. The bench holds the car high until long_done rises, and in a separate pass drops the car early. It then judges that each pass gives exactly one start pulse and a single move to farmroad yellow, with the counter cleared on the next edge.

The second coincidence is the counter reaching saturation in the same cycle as a start pulse. The bench parks in highway green until the count saturates, then raises the car. It checks that the flags clear after that edge rather than staying at their saturated values. It also checks that withdrawing the car in the pulse cycle cancels the pulse.

// File: rtl/tl_pkg.sv
package tl_pkg;

  typedef enum logic [1:0] {
    PH_HWY_GO   = 2'd0,
    PH_HWY_WARN = 2'd1,
    PH_FARM_GO  = 2'd2,
    PH_FARM_WARN = 2'd3
  } phase_t;

  // lamp triple for one road, order {green, yellow, red}
  typedef struct packed {
    logic green;
    logic yellow;
    logic red;
  } lamp_t;

  localparam int ROAD_HWY  = 0;
  localparam int ROAD_FARM = 1;
  localparam int NUM_ROADS = 2;

  // next phase as a pure function of the current phase and the three conditions
  function automatic phase_t next_phase(input phase_t cur, input logic car,
                                        input logic short_exp, input logic long_exp);
    phase_t n;
    n = cur;
    case (cur)
      PH_HWY_GO:    if (car && long_exp)  n = PH_HWY_WARN;
      PH_HWY_WARN:  if (short_exp)        n = PH_FARM_GO;
      PH_FARM_GO:   if (long_exp || !car) n = PH_FARM_WARN;
      PH_FARM_WARN: if (short_exp)        n = PH_HWY_GO;
      default:      n = PH_HWY_GO;
    endcase
    return n;
  endfunction

  // lamp triple lit for a road in a given phase
  function automatic lamp_t lamp_for(input phase_t ph, input int road);
    lamp_t l;
    l = '{green: 1'b0, yellow: 1'b0, red: 1'b1};
    if (road == ROAD_HWY) begin
      if (ph == PH_HWY_GO)   l = '{green: 1'b1, yellow: 1'b0, red: 1'b0};
      if (ph == PH_HWY_WARN) l = '{green: 1'b0, yellow: 1'b1, red: 1'b0};
    end else begin
      if (ph == PH_FARM_GO)   l = '{green: 1'b1, yellow: 1'b0, red: 1'b0};
      if (ph == PH_FARM_WARN) l = '{green: 1'b0, yellow: 1'b1, red: 1'b0};
    end
    return l;
  endfunction

  // a saturating count has reached a limit
  function automatic logic count_reached(input int unsigned count, input int unsigned limit);
    return count >= limit;
  endfunction

endpackage

// File: rtl/tl_interval_timer.sv
module tl_interval_timer #(
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 8,
  localparam int CNT_W = $clog2(LONG_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] count,
  output logic             short_exp,
  output logic             long_exp
);
  import tl_pkg::*;

  localparam logic [CNT_W-1:0] LONG_V = CNT_W'(LONG_CYC);

  logic saturated;
  assign saturated = (count == LONG_V);

  always_ff @(posedge clk) begin
    if (rst || restart)  count <= '0;
    else if (!saturated) count <= count + 1'b1;
  end

  assign short_exp = count_reached(int'(count), SHORT_CYC);
  assign long_exp  = count_reached(int'(count), LONG_CYC);

endmodule

// File: rtl/tl_phase_seq.sv
module tl_phase_seq (
  input  logic           clk,
  input  logic           rst,
  input  logic           car,
  input  logic           short_exp,
  input  logic           long_exp,
  output tl_pkg::phase_t phase_q,
  output logic           change
);
  import tl_pkg::*;

  phase_t phase_d;

  always_comb phase_d = next_phase(phase_q, car, short_exp, long_exp);

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_HWY_GO;
    else     phase_q <= phase_d;
  end

  assign change = !rst && (phase_d != phase_q);

endmodule

// File: rtl/tl_lamp_decode.sv
module tl_lamp_decode (
  input  tl_pkg::phase_t phase,
  output tl_pkg::lamp_t  lamps [tl_pkg::NUM_ROADS]
);
  import tl_pkg::*;

  for (genvar r = 0; r < NUM_ROADS; r++) begin : g_road
    assign lamps[r] = lamp_for(phase, r);
  end

endmodule

// File: rtl/hwy_farm_light_ctrl.sv
module hwy_farm_light_ctrl #(
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic car_waiting,
  output logic hwy_green,
  output logic hwy_yellow,
  output logic hwy_red,
  output logic farm_green,
  output logic farm_yellow,
  output logic farm_red,
  output logic start_timer,
  output logic short_done,
  output logic long_done
);
  import tl_pkg::*;

  localparam int CNT_W = $clog2(LONG_CYC + 1);

  // named internal events for the checker
  phase_t           phase_q;
  logic             phase_change;
  logic [CNT_W-1:0] interval_count;
  lamp_t            road_lamps [NUM_ROADS];

  tl_interval_timer #(
    .SHORT_CYC(SHORT_CYC),
    .LONG_CYC (LONG_CYC)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .restart  (phase_change),
    .count    (interval_count),
    .short_exp(short_done),
    .long_exp (long_done)
  );

  tl_phase_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .car      (car_waiting),
    .short_exp(short_done),
    .long_exp (long_done),
    .phase_q  (phase_q),
    .change   (phase_change)
  );

  tl_lamp_decode u_lamps (
    .phase(phase_q),
    .lamps(road_lamps)
  );

  assign start_timer = phase_change;
  assign hwy_green   = road_lamps[ROAD_HWY].green;
  assign hwy_yellow  = road_lamps[ROAD_HWY].yellow;
  assign hwy_red     = road_lamps[ROAD_HWY].red;
  assign farm_green  = road_lamps[ROAD_FARM].green;
  assign farm_yellow = road_lamps[ROAD_FARM].yellow;
  assign farm_red    = road_lamps[ROAD_FARM].red;

endmodule

// File: rtl/hwy_farm_light_ctrl_chk.sv
module hwy_farm_light_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic car_waiting,
  input logic hwy_green,
  input logic hwy_yellow,
  input logic hwy_red,
  input logic farm_green,
  input logic farm_yellow,
  input logic farm_red,
  input logic start_timer,
  input logic short_done,
  input logic long_done
);
  logic [5:0] lamp_vec;
  assign lamp_vec = {hwy_green, hwy_yellow, hwy_red, farm_green, farm_yellow, farm_red};

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (hwy_green && farm_red && !short_done && !long_done && !start_timer));

  assert_one_lamp_R2: assert property (@(posedge clk) disable iff (rst)
    ($countones({hwy_green, hwy_yellow, hwy_red}) == 1) &&
    ($countones({farm_green, farm_yellow, farm_red}) == 1));

  assert_hwy_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (hwy_green && !(car_waiting && long_done)) |=> hwy_green);

  assert_hwy_warn_exit_R4: assert property (@(posedge clk) disable iff (rst)
    (hwy_yellow && short_done) |=> farm_green);

  assert_farm_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (farm_green && (long_done || !car_waiting)) |=> farm_yellow);

  assert_farm_warn_exit_R6: assert property (@(posedge clk) disable iff (rst)
    (farm_yellow && short_done) |=> hwy_green);

  assert_pulse_changes_R7: assert property (@(posedge clk) disable iff (rst)
    start_timer |=> !$stable(lamp_vec));

  assert_no_pulse_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !start_timer |=> $stable(lamp_vec));

  assert_flags_clear_R8: assert property (@(posedge clk) disable iff (rst)
    start_timer |=> (!short_done && !long_done));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (short_done && !start_timer) |=> short_done);

  assert_flag_order_R8: assert property (@(posedge clk) disable iff (rst)
    long_done |-> short_done);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (hwy_green && !car_waiting) |-> !start_timer);

endmodule

bind hwy_farm_light_ctrl hwy_farm_light_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .car_waiting(car_waiting),
  .hwy_green  (hwy_green),
  .hwy_yellow (hwy_yellow),
  .hwy_red    (hwy_red),
  .farm_green (farm_green),
  .farm_yellow(farm_yellow),
  .farm_red   (farm_red),
  .start_timer(start_timer),
  .short_done (short_done),
  .long_done  (long_done)
);

// File: tb/hwy_farm_light_ctrl_tb.sv
module hwy_farm_light_ctrl_tb;

  localparam int SHORT = 3;
  localparam int LONG  = 8;

  // lamp patterns {hg,hy,hr,fg,fy,fr}
  localparam logic [5:0] P_HG = 6'b100_001;
  localparam logic [5:0] P_HY = 6'b010_001;
  localparam logic [5:0] P_FG = 6'b001_100;
  localparam logic [5:0] P_FY = 6'b001_010;

  typedef struct packed {
    logic       car;
    logic [7:0] hold;
    logic [5:0] lamps;
    logic       st;
    logic       sh;
    logic       lg;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'd12, P_HG, 1'b0, 1'b1, 1'b1, 4'd9}, // R9 idle highway past long
    '{1'b1, 8'd1,  P_HY, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 car plus long exits
    '{1'b1, 8'd3,  P_HY, 1'b1, 1'b1, 1'b0, 4'd8}, // R8 short after SHORT edges
    '{1'b1, 8'd1,  P_FG, 1'b0, 1'b0, 1'b0, 4'd4}, // R4
    '{1'b1, 8'd7,  P_FG, 1'b0, 1'b1, 1'b0, 4'd5}, // R5 held while car and not long
    '{1'b1, 8'd1,  P_FG, 1'b1, 1'b1, 1'b1, 4'd7}, // R7 pulse at long
    '{1'b1, 8'd1,  P_FY, 1'b0, 1'b0, 1'b0, 4'd5}, // R5 long exit
    '{1'b1, 8'd3,  P_FY, 1'b1, 1'b1, 1'b0, 4'd7}, // R7
    '{1'b1, 8'd1,  P_HG, 1'b0, 1'b0, 1'b0, 4'd6}, // R6
    '{1'b1, 8'd7,  P_HG, 1'b0, 1'b1, 1'b0, 4'd3}, // R3 car but not long
    '{1'b1, 8'd1,  P_HG, 1'b1, 1'b1, 1'b1, 4'd7}, // R7 pulse ready
    '{1'b0, 8'd1,  P_HG, 1'b0, 1'b1, 1'b1, 4'd3}, // R3 car withdrawn cancels
    '{1'b1, 8'd1,  P_HY, 1'b0, 1'b0, 1'b0, 4'd3}, // R3
    '{1'b0, 8'd4,  P_FG, 1'b1, 1'b0, 1'b0, 4'd4}, // R4 car ignored in yellow
    '{1'b0, 8'd1,  P_FY, 1'b0, 1'b0, 1'b0, 4'd5}, // R5 early exit no car
    '{1'b0, 8'd3,  P_FY, 1'b1, 1'b1, 1'b0, 4'd6}, // R6
    '{1'b0, 8'd1,  P_HG, 1'b0, 1'b0, 1'b0, 4'd6}, // R6
    '{1'b0, 8'd20, P_HG, 1'b0, 1'b1, 1'b1, 4'd9}  // R9 long idle
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic car_waiting = 1'b0;
  logic hwy_green, hwy_yellow, hwy_red, farm_green, farm_yellow, farm_red;
  logic start_timer, short_done, long_done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hwy_farm_light_ctrl #(.SHORT_CYC(SHORT), .LONG_CYC(LONG)) u_dut (
    .clk(clk), .rst(rst), .car_waiting(car_waiting),
    .hwy_green(hwy_green), .hwy_yellow(hwy_yellow), .hwy_red(hwy_red),
    .farm_green(farm_green), .farm_yellow(farm_yellow), .farm_red(farm_red),
    .start_timer(start_timer), .short_done(short_done), .long_done(long_done)
  );

  function automatic logic [8:0] observed();
    return {hwy_green, hwy_yellow, hwy_red, farm_green, farm_yellow, farm_red,
            start_timer, short_done, long_done};
  endfunction

  task automatic check(input string tag, input logic [8:0] exp);
    logic [8:0] act;
    act = observed();
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s lamps/st/sh/lg actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 reset", {P_HG, 3'b000});
    car_waiting = 1'b1;
    @(negedge clk);
    check("R1 no pulse in reset", {P_HG, 3'b000});
    car_waiting = 1'b0;
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      car_waiting = VECS[i].car;
      repeat (int'(VECS[i].hold)) @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            {VECS[i].lamps, VECS[i].st, VECS[i].sh, VECS[i].lg});
    end

    // R1: reset in mid-sequence (highway yellow with short flag high)
    car_waiting = 1'b1;
    @(negedge clk);
    check("R3 leave before reset test", {P_HY, 3'b000});
    repeat (SHORT) @(negedge clk);
    check("R8 short flag before reset", {P_HY, 3'b110});
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-sequence reset", {P_HG, 3'b000});
    rst = 1'b0;
    car_waiting = 1'b0;

    // R8: short flag rises exactly at SHORT edges after clearing
    repeat (SHORT - 1) @(negedge clk);
    check("R8 short not yet", {P_HG, 3'b000});
    @(negedge clk);
    check("R8 short exact", {P_HG, 3'b010});
    repeat (LONG - SHORT - 1) @(negedge clk);
    check("R8 long not yet", {P_HG, 3'b010});
    @(negedge clk);
    check("R8 long exact", {P_HG, 3'b011});

    // R2: lamp one-hot swept over a full cycle
    car_waiting = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      checks++;
      if ($countones({hwy_green, hwy_yellow, hwy_red}) != 1 ||
          $countones({farm_green, farm_yellow, farm_red}) != 1) begin
        failures++;
        $display("FAIL R2 lamps actual=%b expected one per road",
                 {hwy_green, hwy_yellow, hwy_red, farm_green, farm_yellow, farm_red});
      end
    end

    finish_run();
  end

endmodule